// File: doc/BRIEF.md
# Burst Beat Counter Controller

This block sequences the burst indicators of a bus master for a single queued transfer. A command strobe loads a beat count, a direction, a flag saying whether the transfer is a burst, and four request qualifiers. The block then counts data-beat acknowledges. It raises the read-burst or the write-burst indicator while more than one beat remains, and it lowers the indicator so that the last beat goes out with the indicator low. A one-clock done pulse marks the acknowledge of the last beat.

Two behaviours change the plain count. A slave terminate request lowers the indicator at once and freezes the counter; the next acknowledge is then the last one. A live configuration input lets the burst run past its programmed count, and in that case only a terminate ends it. The four qualifier outputs repeat the latched command bits while the request phase is active and are 0 otherwise. Data and address paths are handled elsewhere.

Top module: `beat_burst_unit`

## Requirements
- R1: While `rstN` is low, and from the moment it goes low, `rdBurst`, `wrBurst`, `xferDone`, `beatCnt` and all four qualifier outputs are 0.
- R2: While idle, `cmdValid` accepts a command at a clock edge. For an effective length of 2 or more, `rdBurst` (when `cmdIsRead`=1) or `wrBurst` (when `cmdIsRead`=0) is 1 from that edge, and `beatCnt` is 0. A `cmdValid` while a transfer is active is ignored.
- R3: When `cmdIsBurst`=0, the effective length is 1 and `cmdBurstLen` is ignored. With an effective length of 1, neither burst indicator is raised, and the first `beatAck` is the last beat.
- R4: With `overrunEn`=0 and no terminate, the indicator falls at the edge that samples the acknowledge of beat number length-1. The transfer ends with the acknowledge of beat number length, so it takes exactly length acknowledges.
- R5: `xferDone` is 1 for exactly the one cycle after the edge that samples the last beat's acknowledge. In that cycle `beatCnt` is 0, and a new command may be accepted.
- R6: With `overrunEn`=1, the indicator stays high after the programmed count has been reached, and acknowledges keep counting until a terminate arrives.
- R7: `slaveTerm` sampled while an indicator is high lowers it at that edge, and `beatCnt` keeps its value, even when `beatAck` is high at the same edge.
- R8: Once the indicator is low during an active transfer, the next `beatAck` is the last beat. A terminate at that point has no effect.
- R9: The qualifier outputs are compress (bit 0 of `cmdQual`), guarded (bit 1), ordered (bit 2) and lock error (bit 3). Each equals its latched bit while `reqPhase`=1 and a transfer is active, and is 0 otherwise.
- R10: `beatCnt` rises by one for each `beatAck` sampled while an indicator is high, saturates at 2^CNT_W-1, and does not change on cycles without `beatAck`.
- R11: `cmdBurstLen`=0 together with `cmdIsBurst`=1 behaves as a length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe |
| cmdBurstLen | input | CNT_W | Programmed number of beats |
| cmdIsRead | input | 1 | 1 = read, 0 = write |
| cmdIsBurst | input | 1 | Command uses burst size |
| cmdQual | input | 4 | Qualifier bits: compress, guarded, ordered, lock error (bit 0 to 3) |
| beatAck | input | 1 | Data beat acknowledge |
| slaveTerm | input | 1 | Slave request to end the burst |
| reqPhase | input | 1 | Request phase active |
| overrunEn | input | 1 | Allow bursting past the count |
| rdBurst | output | 1 | Read burst indicator |
| wrBurst | output | 1 | Write burst indicator |
| xferDone | output | 1 | One-clock pulse for the last beat |
| beatCnt | output | CNT_W | Counted beats |
| compressOut | output | 1 | Compress qualifier |
| guardedOut | output | 1 | Guarded qualifier |
| orderedOut | output | 1 | Ordered qualifier |
| lockErrOut | output | 1 | Lock error qualifier |

## Verification
The burst indicators, `beatCnt` and `xferDone` are registered. Each therefore changes one edge after the command, acknowledge or terminate that causes it, and the bench samples them 1 ns after that edge. The qualifier outputs depend combinationally on `reqPhase`, so the bench checks them after a short settle delay in the same cycle in which it changes `reqPhase`. Sweeps over length, direction, burst flag, acknowledge spacing and terminate position are compared against a cycle model built from the requirements.

// File: rtl/beat_burst_pkg.sv
package beat_burst_pkg;
  localparam int QUAL_W = 4;
  localparam int Q_COMPRESS = 0;
  localparam int Q_GUARDED  = 1;
  localparam int Q_ORDERED  = 2;
  localparam int Q_LOCKERR  = 3;

  typedef struct packed {
    logic load;
    logic inc;
    logic clr;
  } dpStrobe_t;
endpackage

// File: rtl/beat_burst_dp.sv
module beat_burst_dp
  import beat_burst_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CNT_W-1:0]  cmdBurstLen,
  input  logic              cmdIsBurst,
  input  logic              cmdIsRead,
  input  logic [QUAL_W-1:0] cmdQual,
  output logic [CNT_W-1:0]  beatCnt,
  output logic              isRead,
  output logic [QUAL_W-1:0] qualReg,
  output logic              multiBeatCmd,
  output logic              atDropPoint
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO     = CNT_W'(2);

  logic [CNT_W-1:0] lenReg;
  logic [CNT_W-1:0] lenNext;
  logic             cntSat;

  always_comb begin
    if (!cmdIsBurst || cmdBurstLen == '0) lenNext = ONE;
    else                                  lenNext = cmdBurstLen;
  end

  assign multiBeatCmd = (lenNext >= TWO);
  assign cntSat       = (beatCnt == CNT_MAX);
  assign atDropPoint  = (beatCnt == lenReg - TWO);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenReg  <= ONE;
      beatCnt <= '0;
      isRead  <= 1'b0;
      qualReg <= '0;
    end else if (strobe.load) begin
      lenReg  <= lenNext;
      beatCnt <= '0;
      isRead  <= cmdIsRead;
      qualReg <= cmdQual;
    end else if (strobe.clr) begin
      beatCnt <= '0;
    end else if (strobe.inc && !cntSat) begin
      beatCnt <= beatCnt + ONE;
    end
  end
endmodule

// File: rtl/beat_burst_seq.sv
module beat_burst_seq
  import beat_burst_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      beatAck,
  input  logic      slaveTerm,
  input  logic      overrunEn,
  input  logic      multiBeatCmd,
  input  logic      atDropPoint,
  output dpStrobe_t strobe,
  output logic      active,
  output logic      burstOn,
  output logic      doneOut
);
  logic accept;
  logic finalBeat;
  logic dropNow;

  assign accept    = cmdValid && !active;
  assign finalBeat = active && beatAck && !burstOn;
  assign dropNow   = burstOn && (slaveTerm || (beatAck && !overrunEn && atDropPoint));

  always_comb begin
    strobe      = '0;
    strobe.load = accept;
    strobe.clr  = finalBeat;
    strobe.inc  = active && burstOn && beatAck && !slaveTerm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      burstOn <= 1'b0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= finalBeat;
      if (accept) begin
        active  <= 1'b1;
        burstOn <= multiBeatCmd;
      end else begin
        if (finalBeat) active  <= 1'b0;
        if (dropNow)   burstOn <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/beat_burst_unit.sv
module beat_burst_unit
  import beat_burst_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CNT_W-1:0]  cmdBurstLen,
  input  logic              cmdIsRead,
  input  logic              cmdIsBurst,
  input  logic [3:0]        cmdQual,
  input  logic              beatAck,
  input  logic              slaveTerm,
  input  logic              reqPhase,
  input  logic              overrunEn,
  output logic              rdBurst,
  output logic              wrBurst,
  output logic              xferDone,
  output logic [CNT_W-1:0]  beatCnt,
  output logic              compressOut,
  output logic              guardedOut,
  output logic              orderedOut,
  output logic              lockErrOut
);
  dpStrobe_t         strobe;
  logic              active;
  logic              burstOn;
  logic              isRead;
  logic [QUAL_W-1:0] qualReg;
  logic [QUAL_W-1:0] qualGated;
  logic              multiBeatCmd;
  logic              atDropPoint;

  beat_burst_seq u_seq (
    .clk          (clk),
    .rstN         (rstN),
    .cmdValid     (cmdValid),
    .beatAck      (beatAck),
    .slaveTerm    (slaveTerm),
    .overrunEn    (overrunEn),
    .multiBeatCmd (multiBeatCmd),
    .atDropPoint  (atDropPoint),
    .strobe       (strobe),
    .active       (active),
    .burstOn      (burstOn),
    .doneOut      (xferDone)
  );

  beat_burst_dp #(.CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cmdBurstLen  (cmdBurstLen),
    .cmdIsBurst   (cmdIsBurst),
    .cmdIsRead    (cmdIsRead),
    .cmdQual      (cmdQual),
    .beatCnt      (beatCnt),
    .isRead       (isRead),
    .qualReg      (qualReg),
    .multiBeatCmd (multiBeatCmd),
    .atDropPoint  (atDropPoint)
  );

  assign rdBurst = burstOn && isRead;
  assign wrBurst = burstOn && !isRead;

  for (genvar q = 0; q < QUAL_W; q++) begin : g_qual
    assign qualGated[q] = qualReg[q] && active && reqPhase;
  end

  assign compressOut = qualGated[Q_COMPRESS];
  assign guardedOut  = qualGated[Q_GUARDED];
  assign orderedOut  = qualGated[Q_ORDERED];
  assign lockErrOut  = qualGated[Q_LOCKERR];
endmodule

// File: rtl/beat_burst_chk.sv
module beat_burst_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic             beatAck,
  input logic             slaveTerm,
  input logic             reqPhase,
  input logic             rdBurst,
  input logic             wrBurst,
  input logic             xferDone,
  input logic [CNT_W-1:0] beatCnt,
  input logic             compressOut,
  input logic             guardedOut,
  input logic             orderedOut,
  input logic             lockErrOut
);
  // R2
  one_direction_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdBurst && wrBurst));

  // R2
  burst_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdBurst || wrBurst) |-> $past(cmdValid) && beatCnt == '0);

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);

  // R5
  done_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> beatCnt == '0 && !rdBurst && !wrBurst);

  // R8
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferDone) |-> $past(beatAck));

  // R7
  term_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    slaveTerm && (rdBurst || wrBurst) |=> !rdBurst && !wrBurst && !xferDone);

  // R7
  term_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    slaveTerm && (rdBurst || wrBurst) |=> $stable(beatCnt));

  // R10
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    !beatAck && !cmdValid |=> $stable(beatCnt));

  // R9
  qual_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqPhase |-> !compressOut && !guardedOut && !orderedOut && !lockErrOut);
endmodule

bind beat_burst_unit beat_burst_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .beatAck     (beatAck),
  .slaveTerm   (slaveTerm),
  .reqPhase    (reqPhase),
  .rdBurst     (rdBurst),
  .wrBurst     (wrBurst),
  .xferDone    (xferDone),
  .beatCnt     (beatCnt),
  .compressOut (compressOut),
  .guardedOut  (guardedOut),
  .orderedOut  (orderedOut),
  .lockErrOut  (lockErrOut)
);

// File: tb/beat_burst_unit_tb.sv
`timescale 1ns/1ps
module beat_burst_unit_tb;
  localparam int CNT_W   = 8;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cmdValid = 1'b0;
  logic [CNT_W-1:0] cmdBurstLen = '0;
  logic             cmdIsRead = 1'b0;
  logic             cmdIsBurst = 1'b0;
  logic [3:0]       cmdQual = '0;
  logic             beatAck = 1'b0;
  logic             slaveTerm = 1'b0;
  logic             reqPhase = 1'b0;
  logic             overrunEn = 1'b0;
  logic             rdBurst, wrBurst, xferDone;
  logic [CNT_W-1:0] beatCnt;
  logic             compressOut, guardedOut, orderedOut, lockErrOut;

  int nChecks = 0;
  int nFail   = 0;

  beat_burst_unit #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdBurstLen(cmdBurstLen),
    .cmdIsRead(cmdIsRead), .cmdIsBurst(cmdIsBurst), .cmdQual(cmdQual),
    .beatAck(beatAck), .slaveTerm(slaveTerm), .reqPhase(reqPhase),
    .overrunEn(overrunEn), .rdBurst(rdBurst), .wrBurst(wrBurst),
    .xferDone(xferDone), .beatCnt(beatCnt), .compressOut(compressOut),
    .guardedOut(guardedOut), .orderedOut(orderedOut), .lockErrOut(lockErrOut)
  );

  always #2.5 clk = ~clk;

  function automatic logic [3:0] qualVec();
    return {lockErrOut, orderedOut, guardedOut, compressOut};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // one transfer against a cycle model taken from the requirements
  task automatic runBurst(input int len, input bit rd, input bit isB, input bit ovr,
                          input int termAt, input int gap);
    int  effLen;
    bit  expBurst;
    int  expCnt;
    int  oldCnt;
    bit  done;
    int  acks;
    effLen = (!isB || len == 0) ? 1 : len;
    cmdValid = 1'b1; cmdBurstLen = CNT_W'(len); cmdIsRead = rd;
    cmdIsBurst = isB; overrunEn = ovr;
    step();
    cmdValid = 1'b0;
    expBurst = (effLen >= 2);
    chk("R2 rdBurst at accept", int'(rdBurst), int'(expBurst && rd));
    chk("R3 wrBurst at accept", int'(wrBurst), int'(expBurst && !rd));
    chk("R2 beatCnt at accept", int'(beatCnt), 0);
    expCnt = 0; done = 1'b0; acks = 0;
    while (!done && acks < 400) begin
      for (int g = 0; g < gap; g++) begin
        step();
        chk("R10 idle keeps beatCnt", int'(beatCnt), expCnt);
        chk("R10 idle keeps burst", int'(rdBurst || wrBurst), int'(expBurst));
        chk("R5 no done while idle", int'(xferDone), 0);
      end
      beatAck = 1'b1;
      slaveTerm = (acks == termAt);
      step();
      beatAck = 1'b0;
      oldCnt = expCnt;
      if (!expBurst) begin
        done = 1'b1; expCnt = 0;
      end else if (acks == termAt) begin
        expBurst = 1'b0;
      end else begin
        if (expCnt < CNT_MAX) expCnt++;
        if (!ovr && oldCnt == effLen - 2) expBurst = 1'b0;
      end
      slaveTerm = 1'b0;
      acks++;
      chk("R5 xferDone timing", int'(xferDone), int'(done));
      chk("R10 beatCnt", int'(beatCnt), expCnt);
      chk("R4 R6 rdBurst", int'(rdBurst), int'(expBurst && rd));
      chk("R4 R6 wrBurst", int'(wrBurst), int'(expBurst && !rd));
    end
    if (!ovr && (termAt < 0 || termAt >= effLen - 1))
      chk("R4 R11 acknowledge count", acks, effLen);
    if (termAt >= 0 && termAt < effLen - 1)
      chk("R7 R8 acknowledge count after terminate", acks, termAt + 2);
    step();
    chk("R5 done is one cycle", int'(xferDone), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    // R1 reset state
    step(); step();
    chk("R1 rdBurst in reset", int'(rdBurst), 0);
    chk("R1 wrBurst in reset", int'(wrBurst), 0);
    chk("R1 xferDone in reset", int'(xferDone), 0);
    chk("R1 beatCnt in reset", int'(beatCnt), 0);
    chk("R1 qualifiers in reset", int'(qualVec()), 0);
    rstN = 1'b1;
    step();

    // R2 R3 R4 R11 sweep: length, direction, burst flag, ack spacing
    for (int l = 0; l <= 6; l++)
      for (int d = 0; d < 2; d++)
        for (int b = 0; b < 2; b++)
          runBurst(l, d[0], b[0], 1'b0, -1, (l + d) % 3);

    // R7 R8 terminate at each beat position of a 5-beat burst
    for (int t = 0; t <= 5; t++) runBurst(5, t[0], 1'b1, 1'b0, t, t % 2);

    // R6 overrun past the count, then terminate
    runBurst(3, 1'b1, 1'b1, 1'b1, 6, 0);
    runBurst(1, 1'b0, 1'b1, 1'b1, 4, 0);
    // R10 saturation while overrunning
    runBurst(2, 1'b0, 1'b1, 1'b1, 262, 0);

    // R9 qualifier sweep
    for (int q = 0; q < 16; q++) begin
      cmdValid = 1'b1; cmdBurstLen = 8'd1; cmdIsBurst = 1'b0; cmdQual = 4'(q);
      reqPhase = 1'b1; overrunEn = 1'b0;
      #1;
      chk("R9 qualifiers before accept", int'(qualVec()), 0);
      step();
      cmdValid = 1'b0; cmdQual = 4'(~q);
      #1;
      chk("R9 qualifiers in request phase", int'(qualVec()), q);
      reqPhase = 1'b0;
      #1;
      chk("R9 qualifiers outside request phase", int'(qualVec()), 0);
      reqPhase = 1'b1;
      beatAck = 1'b1;
      step();
      beatAck = 1'b0;
      chk("R9 done for single beat", int'(xferDone), 1);
      chk("R9 qualifiers after done", int'(qualVec()), 0);
      reqPhase = 1'b0;
      step();
    end

    // R2 command during an active transfer is ignored
    cmdValid = 1'b1; cmdBurstLen = 8'd3; cmdIsBurst = 1'b1; cmdIsRead = 1'b0;
    cmdQual = 4'b0101; reqPhase = 1'b1;
    step();
    cmdBurstLen = 8'd1; cmdIsRead = 1'b1; cmdIsBurst = 1'b0; cmdQual = 4'b1010;
    step();
    cmdValid = 1'b0;
    chk("R2 busy command keeps write burst", int'(wrBurst), 1);
    chk("R2 busy command gives no read burst", int'(rdBurst), 0);
    chk("R2 busy command keeps qualifiers", int'(qualVec()), 5);
    for (int a = 0; a < 3; a++) begin
      beatAck = 1'b1;
      step();
      beatAck = 1'b0;
      chk("R2 busy command keeps length", int'(xferDone), int'(a == 2));
    end
    reqPhase = 1'b0;
    step();

    // R1 asynchronous reset in the middle of a burst
    cmdValid = 1'b1; cmdBurstLen = 8'd4; cmdIsBurst = 1'b1; cmdIsRead = 1'b1;
    step();
    cmdValid = 1'b0;
    beatAck = 1'b1;
    step();
    beatAck = 1'b0;
    rstN = 1'b0;
    #1;
    chk("R1 reset clears burst", int'(rdBurst || wrBurst), 0);
    chk("R1 reset clears beatCnt", int'(beatCnt), 0);
    step();
    rstN = 1'b1;
    step();

    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule